// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of a single-data-rate SDRAM. From reset it owns the command pins, clock enable, byte masks, address and bank select. It keeps the bus quiet for the power-up pause. It then closes both banks, runs the start-up auto refresh cycles and programs the mode register. Each step is spaced by the row precharge time, the row cycle time or the two-clock mode-write gap. After the last of those gaps has run out it raises `ready`.

Once ready, it keeps a refresh interval timer that produces one refresh obligation on average every 15.6 us, which gives 1024 rows per 16 ms. Obligations collect in a small pending counter. While any are owed and the sequencer is idle, it raises `ref_req`. The user side answers with `ref_gnt` once both banks are idle, and the sequencer then issues one auto refresh followed by NOPs for the row cycle time. All timings are given in nanoseconds and turned into clock counts at elaboration by dividing by the clock period and rounding up.

Top module: `sdr_bringup_sched`

## Requirements
- R1: `cke` and every `dqm` bit are high at all times from reset. The command is NOP ({cs_n,ras_n,cas_n,we_n}=0111) for the first PAUSE_CYC cycles after reset is released.
- R2: In cycle PAUSE_CYC after reset release, a precharge-all is driven: command 0010, `addr` with only bit 8 set, and `ba` low.
- R3: After a precharge, only NOPs are driven for RP_CYC-1 cycles. The next command comes exactly RP_CYC cycles after it.
- R4: During start-up, INIT_REFRESHES auto refreshes (command 0001, `addr` zero) are issued. Each one is followed only by NOPs for RC_CYC-1 cycles, and the next start-up command comes exactly RC_CYC cycles later.
- R5: The mode write is command 0000 with `addr[2:0]`=BL_CODE, `addr[3]`=INTERLEAVE, `addr[6:4]`=CL_CODE, `addr[8:7]` low and `ba`=SINGLE_WRITE. `ba` is low with every other command. With MRS_FIRST=0 the mode write follows the refreshes. With MRS_FIRST=1 it comes first.
- R6: A mode write is followed by NOPs for MRD_CYC-1 cycles. The next command or `ready` comes exactly MRD_CYC cycles later.
- R7: `ready` rises in the cycle in which the gap after the final setup command expires, and it stays high until reset.
- R8: Starting when `ready` rises, one refresh falls due every REFI_CYC cycles. Each time value converts to cycles as ceil(ns*1000/CLK_PERIOD_PS). `ref_req` is high exactly while at least one refresh is owed and the sequencer is idle and ready.
- R9: An auto refresh after start-up is issued only in the cycle after a clock edge that saw both `ref_req` and `ref_gnt` high. While `ref_gnt` is low, owed refreshes are held back.
- R10: The owed count saturates at MAX_OWED. Refreshes that fall due while it is full are dropped, so a held-back grant releases exactly MAX_OWED refreshes, each RC_CYC+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready | output | 1 | Start-up sequence complete |
| ref_req | output | 1 | A refresh is owed; asks the user side to idle the banks |
| ref_gnt | input | 1 | Both banks idle; refresh may be issued |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dqm | output | DQM_W | Byte masks |
| ba | output | 1 | Bank select |
| addr | output | ADDR_W | Address / mode key |

## Verification
The bench checks the exact cycle of every command in both start-up orders. A design that counts a gap one cycle short or long shifts every later command, and the mismatch shows at the first one. The timings are chosen so that rounding up matters. A design that truncates instead gets shorter gaps and issues precharge-to-refresh and refresh-to-refresh one cycle early. The grant is withheld across ten refresh intervals and then released. A counter that does not saturate releases more than eight refreshes, and one that ignores the grant issues refreshes while it is low. The mode word is compared field by field, so a swapped or misplaced field shows up as a wrong address value.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

   typedef enum logic [3:0] {
      ST_PAUSE,
      ST_PRE_ALL,
      ST_WAIT_RP,
      ST_INIT_REF,
      ST_WAIT_RC,
      ST_MODE,
      ST_WAIT_MRD,
      ST_RUN,
      ST_RUN_REF,
      ST_RUN_RC
   } seq_state_t;

   // {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] CMD_NOP      = 4'b0111;
   localparam logic [3:0] CMD_PRE      = 4'b0010;
   localparam logic [3:0] CMD_AUTO_REF = 4'b0001;
   localparam logic [3:0] CMD_MODE_WR  = 4'b0000;

   // Bit of the address bus that selects all banks on precharge.
   localparam int unsigned ALL_BANK_BIT = 8;

   function automatic int unsigned ns_to_cyc(input int unsigned t_ns,
                                             input int unsigned clk_ps);
      return (t_ns * 1000 + clk_ps - 1) / clk_ps;
   endfunction

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned RESET_VAL = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expire
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= CNT_W'(RESET_VAL);
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expire = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sdr_refresh_pacer.sv
module sdr_refresh_pacer #(
   parameter int unsigned REFI_CYC = 3125,
   parameter int unsigned MAX_OWED = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic issued,
   output logic pending
);

   localparam int unsigned IW = $clog2(REFI_CYC + 1);
   localparam int unsigned OW = $clog2(MAX_OWED + 1);

   logic [IW-1:0] ival_q;
   logic [OW-1:0] owed_q;
   logic          tick;

   assign tick = enable && (ival_q == IW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ival_q <= IW'(REFI_CYC);
      else if (enable)
         ival_q <= (ival_q == IW'(1)) ? IW'(REFI_CYC) : ival_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         owed_q <= '0;
      else begin
         case ({tick, issued})
            2'b10:   if (owed_q != OW'(MAX_OWED)) owed_q <= owed_q + 1'b1;
            2'b01:   owed_q <= owed_q - 1'b1;
            default: owed_q <= owed_q;
         endcase
      end
   end

   assign pending = (owed_q != '0);

endmodule

// File: rtl/sdr_mode_word.sv
module sdr_mode_word #(
   parameter int unsigned ADDR_W     = 9,
   parameter logic [2:0]  BL_CODE    = 3'd3,
   parameter logic        INTERLEAVE = 1'b0,
   parameter logic [2:0]  CL_CODE    = 3'd3
) (
   output logic [ADDR_W-1:0] word
);

   logic [8:0] core;
   assign core = {2'b00, CL_CODE, INTERLEAVE, BL_CODE};

   generate
      if (ADDR_W > 9) begin : g_pad
         assign word = {{(ADDR_W-9){1'b0}}, core};
      end else begin : g_exact
         assign word = core;
      end
   endgenerate

endmodule

// File: rtl/sdr_bringup_sched.sv
module sdr_bringup_sched
   import sdr_seq_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_PS  = 5000,
   parameter int unsigned T_PAUSE_NS     = 200000,
   parameter int unsigned T_RP_NS        = 20,
   parameter int unsigned T_RC_NS        = 70,
   parameter int unsigned T_REFI_NS      = 15625,
   parameter int unsigned MRD_CYC        = 2,
   parameter int unsigned INIT_REFRESHES = 2,
   parameter int unsigned MAX_OWED       = 8,
   parameter int unsigned ADDR_W         = 9,
   parameter int unsigned DQM_W          = 2,
   parameter logic [2:0]  BL_CODE        = 3'd3,
   parameter logic        INTERLEAVE     = 1'b0,
   parameter logic [2:0]  CL_CODE        = 3'd3,
   parameter logic        SINGLE_WRITE   = 1'b0,
   parameter bit          MRS_FIRST      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              ready,
   output logic              ref_req,
   input  logic              ref_gnt,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [DQM_W-1:0]  dqm,
   output logic              ba,
   output logic [ADDR_W-1:0] addr
);

   localparam int unsigned PAUSE_CYC = ns_to_cyc(T_PAUSE_NS, CLK_PERIOD_PS);
   localparam int unsigned RP_CYC    = ns_to_cyc(T_RP_NS, CLK_PERIOD_PS);
   localparam int unsigned RC_CYC    = ns_to_cyc(T_RC_NS, CLK_PERIOD_PS);
   localparam int unsigned REFI_CYC  = ns_to_cyc(T_REFI_NS, CLK_PERIOD_PS);
   localparam int unsigned CNT_W     = $clog2(max4(PAUSE_CYC, RP_CYC, RC_CYC, MRD_CYC) + 1);
   localparam int unsigned RL_W      = $clog2(INIT_REFRESHES + 1);
   localparam logic [ADDR_W-1:0] ALL_BANK_WORD = ADDR_W'(1) << ALL_BANK_BIT;

   generate
      if (ADDR_W < 9) begin : g_chk_addr
         $error("ADDR_W must be at least 9");
      end
      if (PAUSE_CYC < 2 || RP_CYC < 2 || RC_CYC < 2 || MRD_CYC < 2) begin : g_chk_gap
         $error("every gap must be at least two cycles");
      end
      if (INIT_REFRESHES < 2) begin : g_chk_refs
         $error("start-up needs at least two refreshes");
      end
      if (MAX_OWED < 1) begin : g_chk_owed
         $error("MAX_OWED must be at least one");
      end
   endgenerate

   seq_state_t       st_q, st_nxt, setup_next;
   logic [RL_W-1:0]  refs_left_q;
   logic             mode_done_q;
   logic             take_mode;
   logic             tmr_load, tmr_done;
   logic [CNT_W-1:0] tmr_val;
   logic             pend;
   logic [ADDR_W-1:0] mode_word;
   logic [3:0]       cmd;

   // ---- start-up ordering variant ----
   generate
      if (MRS_FIRST) begin : g_mode_first
         assign take_mode = !mode_done_q;
      end else begin : g_mode_last
         assign take_mode = !mode_done_q && (refs_left_q == '0);
      end
   endgenerate

   always_comb begin
      if (take_mode)
         setup_next = ST_MODE;
      else if (refs_left_q != '0)
         setup_next = ST_INIT_REF;
      else
         setup_next = ST_RUN;
   end

   // ---- state register ----
   always_comb begin
      st_nxt = st_q;
      case (st_q)
         ST_PAUSE:    if (tmr_done) st_nxt = ST_PRE_ALL;
         ST_PRE_ALL:  st_nxt = ST_WAIT_RP;
         ST_INIT_REF: st_nxt = ST_WAIT_RC;
         ST_MODE:     st_nxt = ST_WAIT_MRD;
         ST_WAIT_RP,
         ST_WAIT_RC,
         ST_WAIT_MRD: if (tmr_done) st_nxt = setup_next;
         ST_RUN:      if (pend && ref_gnt) st_nxt = ST_RUN_REF;
         ST_RUN_REF:  st_nxt = ST_RUN_RC;
         ST_RUN_RC:   if (tmr_done) st_nxt = ST_RUN;
         default:     st_nxt = ST_PAUSE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_PAUSE;
         refs_left_q <= RL_W'(INIT_REFRESHES);
         mode_done_q <= 1'b0;
      end else begin
         st_q <= st_nxt;
         if (st_q == ST_INIT_REF) refs_left_q <= refs_left_q - 1'b1;
         if (st_q == ST_MODE)     mode_done_q <= 1'b1;
      end
   end

   // ---- shared gap timer ----
   always_comb begin
      tmr_load = 1'b1;
      tmr_val  = '0;
      case (st_q)
         ST_PRE_ALL:             tmr_val = CNT_W'(RP_CYC - 1);
         ST_INIT_REF, ST_RUN_REF: tmr_val = CNT_W'(RC_CYC - 1);
         ST_MODE:                tmr_val = CNT_W'(MRD_CYC - 1);
         default:                tmr_load = 1'b0;
      endcase
   end

   sdr_gap_timer #(
      .CNT_W     (CNT_W),
      .RESET_VAL (PAUSE_CYC)
   ) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expire   (tmr_done)
   );

   // ---- refresh pacing ----
   sdr_refresh_pacer #(
      .REFI_CYC (REFI_CYC),
      .MAX_OWED (MAX_OWED)
   ) u_pacer (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (ready),
      .issued  (st_q == ST_RUN_REF),
      .pending (pend)
   );

   sdr_mode_word #(
      .ADDR_W     (ADDR_W),
      .BL_CODE    (BL_CODE),
      .INTERLEAVE (INTERLEAVE),
      .CL_CODE    (CL_CODE)
   ) u_mode (
      .word (mode_word)
   );

   // ---- pin drive ----
   always_comb begin
      cmd  = CMD_NOP;
      addr = '0;
      ba   = 1'b0;
      case (st_q)
         ST_PRE_ALL: begin
            cmd  = CMD_PRE;
            addr = ALL_BANK_WORD;
         end
         ST_INIT_REF, ST_RUN_REF: cmd = CMD_AUTO_REF;
         ST_MODE: begin
            cmd  = CMD_MODE_WR;
            addr = mode_word;
            ba   = SINGLE_WRITE;
         end
         default: cmd = CMD_NOP;
      endcase
   end

   assign {cs_n, ras_n, cas_n, we_n} = cmd;
   assign cke     = 1'b1;
   assign dqm     = '1;
   assign ready   = (st_q == ST_RUN) || (st_q == ST_RUN_REF) || (st_q == ST_RUN_RC);
   assign ref_req = (st_q == ST_RUN) && pend;

endmodule

// File: rtl/sdr_bringup_chk.sv
module sdr_bringup_chk #(
   parameter int unsigned PAUSE_CYC      = 2,
   parameter int unsigned RP_CYC         = 2,
   parameter int unsigned RC_CYC         = 2,
   parameter int unsigned MRD_CYC        = 2,
   parameter int unsigned INIT_REFRESHES = 2,
   parameter int unsigned ADDR_W         = 9,
   parameter int unsigned DQM_W          = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ready,
   input logic              ref_req,
   input logic              ref_gnt,
   input logic              cke,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [DQM_W-1:0]  dqm,
   input logic              ba,
   input logic [ADDR_W-1:0] addr
);

   logic [3:0]  cmd;
   logic        is_nop, is_pre, is_ref, is_mode;
   logic [31:0] boot_q, since_q;
   logic [1:0]  last_q;   // 0 none, 1 precharge, 2 refresh, 3 mode write
   logic [7:0]  refs_q;
   logic        mode_seen_q;

   assign cmd     = {cs_n, ras_n, cas_n, we_n};
   assign is_nop  = (cmd == 4'b0111);
   assign is_pre  = (cmd == 4'b0010);
   assign is_ref  = (cmd == 4'b0001);
   assign is_mode = (cmd == 4'b0000);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boot_q      <= '0;
         since_q     <= '0;
         last_q      <= 2'd0;
         refs_q      <= '0;
         mode_seen_q <= 1'b0;
      end else begin
         if (boot_q != '1) boot_q <= boot_q + 1;
         if (!is_nop) begin
            since_q <= 32'd1;
            last_q  <= is_pre ? 2'd1 : is_ref ? 2'd2 : is_mode ? 2'd3 : last_q;
         end else if (since_q != '1) begin
            since_q <= since_q + 1;
         end
         if (is_ref && !ready && refs_q != '1) refs_q <= refs_q + 1'b1;
         if (is_mode) mode_seen_q <= 1'b1;
      end
   end

   AST_PINS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      cke && (&dqm)); // R1
   AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_q < PAUSE_CYC) |-> is_nop); // R1
   AST_PRE_ALL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> addr[8]); // R2
   AST_RP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_nop && last_q == 2'd1) |-> (since_q >= RP_CYC)); // R3
   AST_RC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_nop && last_q == 2'd2) |-> (since_q >= RC_CYC)); // R4
   AST_REF_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (is_ref || is_nop) |-> (addr == '0)); // R4
   AST_MODE_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      is_mode |-> (addr[8:7] == 2'b00)); // R5
   AST_BA_ONLY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      !is_mode |-> !ba); // R5
   AST_MRD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_nop && last_q == 2'd3) |-> (since_q >= MRD_CYC)); // R6
   AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready); // R7
   AST_READY_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> (mode_seen_q && refs_q >= INIT_REFRESHES)); // R7
   AST_NO_REQ_IN_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !ref_req); // R8
   AST_REF_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && is_ref) |-> $past(ref_req && ref_gnt)); // R9

endmodule

bind sdr_bringup_sched sdr_bringup_chk #(
   .PAUSE_CYC      (PAUSE_CYC),
   .RP_CYC         (RP_CYC),
   .RC_CYC         (RC_CYC),
   .MRD_CYC        (MRD_CYC),
   .INIT_REFRESHES (INIT_REFRESHES),
   .ADDR_W         (ADDR_W),
   .DQM_W          (DQM_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ready   (ready),
   .ref_req (ref_req),
   .ref_gnt (ref_gnt),
   .cke     (cke),
   .cs_n    (cs_n),
   .ras_n   (ras_n),
   .cas_n   (cas_n),
   .we_n    (we_n),
   .dqm     (dqm),
   .ba      (ba),
   .addr    (addr)
);

// File: tb/sim_sdr_bringup_sched.sv
`timescale 1ns/1ps
module sim_sdr_bringup_sched;

   localparam int CLK_PS  = 5000;
   localparam int PAUSE   = 100;  // 500 ns
   localparam int RP      = 3;    // 11 ns rounded up
   localparam int RC      = 12;   // 56 ns rounded up
   localparam int MRD     = 2;
   localparam int REFI    = 120;  // 600 ns
   localparam int OWED    = 8;
   localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;
   localparam logic [8:0] MODE_ADDR = {2'b00, 3'd3, 1'b1, 3'd2};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gnt0 = 1'b1;
   always #2.5 clk = ~clk;

   logic       rdy0, req0, cke0, cs0, ras0, cas0, we0, ba0;
   logic [1:0] dqm0;
   logic [8:0] a0;
   logic       rdy1, req1, cke1, cs1, ras1, cas1, we1, ba1;
   logic [1:0] dqm1;
   logic [8:0] a1;

   sdr_bringup_sched #(
      .CLK_PERIOD_PS(CLK_PS), .T_PAUSE_NS(500), .T_RP_NS(11), .T_RC_NS(56),
      .T_REFI_NS(600), .MRD_CYC(MRD), .INIT_REFRESHES(2), .MAX_OWED(OWED),
      .ADDR_W(9), .DQM_W(2), .BL_CODE(3'd2), .INTERLEAVE(1'b1), .CL_CODE(3'd3),
      .SINGLE_WRITE(1'b1), .MRS_FIRST(1'b0)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .ready(rdy0), .ref_req(req0), .ref_gnt(gnt0),
      .cke(cke0), .cs_n(cs0), .ras_n(ras0), .cas_n(cas0), .we_n(we0),
      .dqm(dqm0), .ba(ba0), .addr(a0)
   );

   sdr_bringup_sched #(
      .CLK_PERIOD_PS(CLK_PS), .T_PAUSE_NS(500), .T_RP_NS(11), .T_RC_NS(56),
      .T_REFI_NS(600), .MRD_CYC(MRD), .INIT_REFRESHES(2), .MAX_OWED(OWED),
      .ADDR_W(9), .DQM_W(2), .BL_CODE(3'd2), .INTERLEAVE(1'b1), .CL_CODE(3'd3),
      .SINGLE_WRITE(1'b1), .MRS_FIRST(1'b1)
   ) u1 (
      .clk(clk), .rst_n(rst_n), .ready(rdy1), .ref_req(req1), .ref_gnt(1'b0),
      .cke(cke1), .cs_n(cs1), .ras_n(ras1), .cas_n(cas1), .we_n(we1),
      .dqm(dqm1), .ba(ba1), .addr(a1)
   );

   typedef struct {
      int         cyc;
      logic [3:0] cmd;
      logic [8:0] addr;
      logic       ba;
      string      req;
   } exp_t;

   exp_t q0[$];
   exp_t q1[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic push(input int unit, input int c, input logic [3:0] cm,
                       input logic [8:0] a, input logic b, input string req);
      exp_t e;
      e.cyc = c; e.cmd = cm; e.addr = a; e.ba = b; e.req = req;
      if (unit == 0) q0.push_back(e); else q1.push_back(e);
   endtask

   task automatic observe(input int unit, input logic [3:0] cm,
                          input logic [8:0] a, input logic b);
      exp_t e;
      if ((unit == 0 && q0.size() == 0) || (unit == 1 && q1.size() == 0)) begin
         check(1'b0, "R9", $sformatf("unit %0d unexpected command", unit), cm, NOP);
         return;
      end
      e = (unit == 0) ? q0.pop_front() : q1.pop_front();
      check(e.cyc == cyc, e.req, $sformatf("unit %0d command cycle", unit), cyc, e.cyc);
      check(e.cmd == cm && e.addr == a && e.ba == b, e.req,
            $sformatf("unit %0d {cmd,ba,addr}", unit), {cm, b, a}, {e.cmd, e.ba, e.addr});
   endtask

   // monitor: compare every non-NOP command against the scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if ({cs0, ras0, cas0, we0} != NOP) observe(0, {cs0, ras0, cas0, we0}, a0, ba0);
         if ({cs1, ras1, cas1, we1} != NOP) observe(1, {cs1, ras1, cas1, we1}, a1, ba1);
      end
   end

   task automatic wait_cyc(input int n);
      while (cyc != n) @(negedge clk);
   endtask

   task automatic finish_run;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // watchdog
   initial begin
      repeat (6000) @(posedge clk);
      check(1'b0, "R8", "watchdog expired", cyc, 1830);
      finish_run();
   end

   initial begin
      // expected commands, u0: refreshes then mode write
      push(0, PAUSE, PRE, 9'h100, 1'b0, "R2");
      push(0, PAUSE + RP, REF, 9'h000, 1'b0, "R3");
      push(0, PAUSE + RP + RC, REF, 9'h000, 1'b0, "R4");
      push(0, PAUSE + RP + 2*RC, MRS, MODE_ADDR, 1'b1, "R5");
      // u1: mode write first
      push(1, PAUSE, PRE, 9'h100, 1'b0, "R2");
      push(1, PAUSE + RP, MRS, MODE_ADDR, 1'b1, "R5");
      push(1, PAUSE + RP + MRD, REF, 9'h000, 1'b0, "R6");
      push(1, PAUSE + RP + MRD + RC, REF, 9'h000, 1'b0, "R4");
      // u0 periodic refreshes: due at 129+120k, issued one cycle later under grant
      push(0, 250, REF, 9'h000, 1'b0, "R8");
      push(0, 370, REF, 9'h000, 1'b0, "R8");
      // grant held back from 381 to 1599: MAX_OWED saved plus one due at 1689
      for (int i = 0; i < OWED + 1; i++)
         push(0, 1600 + i * (RC + 1), REF, 9'h000, 1'b0, "R10");
      push(0, 1810, REF, 9'h000, 1'b0, "R8");

      // reset state
      repeat (3) @(negedge clk);
      check(cke0 && dqm0 == 2'b11 && cke1 && dqm1 == 2'b11, "R1", "cke/dqm in reset",
            {cke0, dqm0}, 3'b111);
      check({cs0, ras0, cas0, we0} == NOP, "R1", "command in reset", {cs0, ras0, cas0, we0}, NOP);
      check(!rdy0 && !req0, "R7", "ready/ref_req in reset", {rdy0, req0}, 0);
      rst_n = 1'b1;

      wait_cyc(50);
      check(cke0 && dqm0 == 2'b11, "R1", "cke/dqm during pause", {cke0, dqm0}, 3'b111);
      wait_cyc(128);
      check(!rdy0, "R7", "u0 ready before mode gap expires", rdy0, 0);
      check(!rdy1, "R7", "u1 ready before refresh gap expires", rdy1, 0);
      wait_cyc(129);
      check(rdy0, "R7", "u0 ready after mode gap", rdy0, 1);
      check(rdy1, "R7", "u1 ready after last refresh gap", rdy1, 1);
      check(!req0, "R8", "no request right after ready", req0, 0);
      wait_cyc(249);
      check(req0, "R8", "request when first refresh due", req0, 1);
      @(negedge clk);
      check(!req0, "R8", "request drops once refresh issued", req0, 0);
      wait_cyc(380);
      gnt0 = 1'b0;
      wait_cyc(488);
      check(!req0, "R8", "no request before next interval", req0, 0);
      wait_cyc(489);
      check(req0, "R9", "request held while grant low", req0, 1);
      wait_cyc(1500);
      check(req0 && rdy0, "R9", "still requesting, nothing issued", {req0, rdy0}, 3);
      check(cke0 && dqm0 == 2'b11, "R1", "cke/dqm in operation", {cke0, dqm0}, 3'b111);
      wait_cyc(1599);
      gnt0 = 1'b1;
      wait_cyc(1720);
      check(!req0, "R10", "owed count drained", req0, 0);
      wait_cyc(1830);
      check(q0.size() == 0, "R10", "u0 commands left unissued", q0.size(), 0);
      check(q1.size() == 0, "R4", "u1 commands left unissued", q1.size(), 0);
      check(rdy0, "R7", "ready stays high", rdy0, 1);
      finish_run();
   end

endmodule